// File: doc/BRIEF.md
# MDIO Management Master with PHY Reset Sequencing

This block lets on-chip logic read and write the management registers of an Ethernet PHY over the two-wire MDC/MDIO interface, using clause-22 frames. A request carries a read/write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block answers with a one-cycle `done` pulse, the 16 bits it read, and a flag that says whether the PHY drove the turnaround bit low. MDC is made from the system clock by an integer half-period divider, and MDIO leaves the block as a data bit plus an output enable for an external tri-state pad.

The PHY needs its reference clock to settle before it can be managed, and it needs time after a hardware reset. After system reset the block therefore keeps MDC low for a long power-up window. It then pulses the PHY reset pin and waits a further delay before it accepts any request. The same reset pulse and wait can be requested again at any idle moment. While a wait or a frame is in progress, `busy` is high and requests are dropped.

Top module: `mdio_master`

## Requirements
- R1: After system reset `busy` is high, `phyRstN` is high, `mdioOe` is low and MDC makes no edge until at least `POWERUP_CYCLES` system cycles have passed.
- R2: The PHY reset output `phyRstN` is low for exactly `RST_PULSE_CYCLES` system cycles once the power-up window ends. The same pulse occurs when `phyRstReq` is seen while idle. `phyRstReq` wins over a simultaneous `reqValid`. MDC stays low while `phyRstN` is low.
- R3: No MDC rising edge occurs within `POST_RST_CYCLES` system cycles after `phyRstN` returns high.
- R4: Every frame opens with MDIO driven high for exactly `PREAMBLE_BITS` MDC rising edges. Values below 32 are raised to 32.
- R5: The 14 header bits follow the preamble as: start bits 0 then 1; the opcode (read 1,0; write 0,1); the PHY address; then the register address. Each address is sent most significant bit first.
- R6: `mdioOut` and `mdioOe` change only while MDC is low and never during its high phase. Inside a frame, MDC rising edges are `2*HALF_DIV` system cycles apart.
- R7: A write drives the turnaround as 1 then 0, then the 16 data bits MSB first. When the block is not busy, `mdioOe` and `mdc` are low.
- R8: A read drops `mdioOe` at the falling edge that ends the 14th header bit. It then captures 16 data bits MSB first on the 16 rising edges after the turnaround, and presents them on `rdData` when `done` rises.
- R9: On a read, `taError` is 1 if MDIO was high at the rising edge of the second turnaround bit and 0 if it was low. Every write clears `taError` to 0.
- R10: PHY address 0 is sent as given, so a PHY that answers on address 0 can be reached.
- R11: `done` lasts one cycle and comes while `busy` is high. MDC stays low for at least one full MDC period after the last frame bit. A `reqValid` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when not busy |
| reqWrite | input | 1 | 1 = write frame, 0 = read frame |
| reqPhyAddr | input | 5 | Target PHY address |
| reqRegAddr | input | 5 | Target register address |
| reqWrData | input | 16 | Data for a write frame |
| phyRstReq | input | 1 | Re-run the PHY reset pulse and post-reset wait (idle only) |
| busy | output | 1 | Wait or frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdData | output | 16 | Last data word read |
| taError | output | 1 | PHY did not pull the read turnaround low |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value to drive |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value sampled from the pad |
| phyRstN | output | 1 | Active-low PHY hardware reset |

## Verification
The block's results arrive at different times. The reset pulse width, the power-up window and the post-reset quiet time are measured in system cycles, counted from the edges of `phyRstN` and `rstN`. Read data and the turnaround flag are final only in the cycle where `done` is high. The bench therefore waits for `done`, sampling at falling clock edges, and compares `rdData` and `taError` in that same cycle, never at a fixed offset from the request. MDIO traffic is checked against a PHY model in the bench, which samples on each MDC rising edge, as a real PHY does. The preamble length, bit order and turnaround pattern are therefore checked bit by bit at the edge where the PHY would see them.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Bits after the preamble: 14 header + 2 turnaround + 16 data
  localparam int FRAME_BITS = 32;
  localparam int HDR_BITS   = 14;
  localparam int TA2_SLOT   = 15;
  localparam int DATA_SLOT0 = 16;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_RST_ASSERT,
    ST_RST_WAIT,
    ST_IDLE,
    ST_PREAMBLE,
    ST_FRAME,
    ST_GAP
  } mdioState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic mdcRun;    // MDC divider running
    logic load;      // capture a new request into the shift register
    logic shift;     // advance the outgoing bit (on an MDC fall)
    logic preamble;  // force MDIO high
    logic oe;        // drive MDIO
    logic taSlot;    // second turnaround bit of a read
    logic dataSlot;  // read data bits
  } mdioStrobes_t;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int POWERUP_CYCLES   = 16_700_000,
  parameter int RST_PULSE_CYCLES = 1000,
  parameter int POST_RST_CYCLES  = 400,
  parameter int PREAMBLE_BITS    = 32,
  parameter int HALF_DIV         = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         phyRstReq,
  input  logic         mdcFall,
  output mdioStrobes_t strb,
  output logic         busy,
  output logic         done,
  output logic         phyRstN
);

  localparam int PRE_EFF  = (PREAMBLE_BITS < 32) ? 32 : PREAMBLE_BITS;
  localparam int GAP_CYC  = 2 * HALF_DIV;
  localparam int MAX_AB   = (POWERUP_CYCLES > RST_PULSE_CYCLES) ? POWERUP_CYCLES : RST_PULSE_CYCLES;
  localparam int MAX_CD   = (POST_RST_CYCLES > GAP_CYC) ? POST_RST_CYCLES : GAP_CYC;
  localparam int WAIT_MAX = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int SLOT_W   = $clog2(PRE_EFF);

  localparam logic [WAIT_W-1:0] PWR_LAST  = WAIT_W'(POWERUP_CYCLES - 1);
  localparam logic [WAIT_W-1:0] RST_LAST  = WAIT_W'(RST_PULSE_CYCLES - 1);
  localparam logic [WAIT_W-1:0] POST_LAST = WAIT_W'(POST_RST_CYCLES - 1);
  localparam logic [WAIT_W-1:0] GAP_LAST  = WAIT_W'(GAP_CYC - 1);
  localparam logic [SLOT_W-1:0] PRE_LAST  = SLOT_W'(PRE_EFF - 1);
  localparam logic [SLOT_W-1:0] FRM_LAST  = SLOT_W'(FRAME_BITS - 1);
  localparam logic [SLOT_W-1:0] HDR_END   = SLOT_W'(HDR_BITS);
  localparam logic [SLOT_W-1:0] TA2       = SLOT_W'(TA2_SLOT);
  localparam logic [SLOT_W-1:0] DATA0     = SLOT_W'(DATA_SLOT0);

  mdioState_t        state;
  logic [WAIT_W-1:0] waitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              opWrite;
  logic              accept;

  assign accept = (state == ST_IDLE) && !phyRstReq && reqValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_PWRUP;
      waitCnt <= '0;
      slotCnt <= '0;
      opWrite <= 1'b0;
    end else begin
      unique case (state)
        ST_PWRUP: begin
          if (waitCnt == PWR_LAST) begin
            state   <= ST_RST_ASSERT;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_RST_ASSERT: begin
          if (waitCnt == RST_LAST) begin
            state   <= ST_RST_WAIT;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_RST_WAIT: begin
          if (waitCnt == POST_LAST) begin
            state   <= ST_IDLE;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (phyRstReq) begin
            state   <= ST_RST_ASSERT;
            waitCnt <= '0;
          end else if (reqValid) begin
            state   <= ST_PREAMBLE;
            slotCnt <= '0;
            opWrite <= reqWrite;
          end
        end
        ST_PREAMBLE: begin
          if (mdcFall) begin
            if (slotCnt == PRE_LAST) begin
              state   <= ST_FRAME;
              slotCnt <= '0;
            end else begin
              slotCnt <= slotCnt + 1'b1;
            end
          end
        end
        ST_FRAME: begin
          if (mdcFall) begin
            if (slotCnt == FRM_LAST) begin
              state   <= ST_GAP;
              waitCnt <= '0;
            end else begin
              slotCnt <= slotCnt + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (waitCnt == GAP_LAST) begin
            state   <= ST_IDLE;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: state <= ST_PWRUP;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.mdcRun   = (state == ST_PREAMBLE) || (state == ST_FRAME);
    strb.load     = accept;
    strb.shift    = (state == ST_FRAME) && mdcFall && (slotCnt != FRM_LAST);
    strb.preamble = (state == ST_PREAMBLE);
    strb.oe       = (state == ST_PREAMBLE) ||
                    ((state == ST_FRAME) && (opWrite || (slotCnt < HDR_END)));
    strb.taSlot   = (state == ST_FRAME) && !opWrite && (slotCnt == TA2);
    strb.dataSlot = (state == ST_FRAME) && !opWrite && (slotCnt >= DATA0);
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_GAP) && (waitCnt == GAP_LAST);
  assign phyRstN = (state != ST_RST_ASSERT);

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdioStrobes_t strb,
  input  logic         reqWrite,
  input  logic [4:0]   reqPhyAddr,
  input  logic [4:0]   reqRegAddr,
  input  logic [15:0]  reqWrData,
  input  logic         mdioIn,
  output logic         mdc,
  output logic         mdioOut,
  output logic         mdioOe,
  output logic         mdcFall,
  output logic [15:0]  rdData,
  output logic         taError
);

  logic                  halfDone;
  logic                  mdcQ;
  logic                  mdcRise;
  logic [FRAME_BITS-1:0] txShift;
  logic [15:0]           rxShift;
  logic                  taErrQ;

  // MDC half-period timer: a divide-by-one variant needs no counter
  generate
    if (HALF_DIV == 1) begin : g_fast
      assign halfDone = 1'b1;
    end else begin : g_div
      localparam int HALF_W = $clog2(HALF_DIV);
      localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF_DIV - 1);
      logic [HALF_W-1:0] halfCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !strb.mdcRun || halfDone) halfCnt <= '0;
        else                                   halfCnt <= halfCnt + 1'b1;
      end
      assign halfDone = (halfCnt == HALF_LAST);
    end
  endgenerate

  assign mdcRise = strb.mdcRun && halfDone && !mdcQ;
  assign mdcFall = strb.mdcRun && halfDone && mdcQ;

  always_ff @(posedge clk) begin
    if (!rstN || !strb.mdcRun) mdcQ <= 1'b0;
    else if (halfDone)         mdcQ <= ~mdcQ;
  end

  // Outgoing frame: start, opcode, addresses, turnaround, data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.load) begin
      txShift <= {2'b01,
                  reqWrite ? 2'b01 : 2'b10,
                  reqPhyAddr,
                  reqRegAddr,
                  reqWrite ? 2'b10 : 2'b00,
                  reqWrite ? reqWrData : 16'h0000};
    end else if (strb.shift) begin
      txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
    end
  end

  // Incoming turnaround check and read data, sampled on MDC rises
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      taErrQ  <= 1'b0;
    end else begin
      if (strb.load)                  taErrQ  <= 1'b0;
      else if (mdcRise && strb.taSlot) taErrQ <= mdioIn;
      if (mdcRise && strb.dataSlot)   rxShift <= {rxShift[14:0], mdioIn};
    end
  end

  assign mdc     = mdcQ;
  assign mdioOut = strb.preamble | txShift[FRAME_BITS-1];
  assign mdioOe  = strb.oe;
  assign rdData  = rxShift;
  assign taError = taErrQ;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int POWERUP_CYCLES   = 16_700_000,
  parameter int RST_PULSE_CYCLES = 1000,
  parameter int POST_RST_CYCLES  = 400,
  parameter int PREAMBLE_BITS    = 32,
  parameter int HALF_DIV         = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [4:0]  reqPhyAddr,
  input  logic [4:0]  reqRegAddr,
  input  logic [15:0] reqWrData,
  input  logic        phyRstReq,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        taError,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn,
  output logic        phyRstN
);

  mdioStrobes_t strb;
  logic         mdcFall;

  mdio_ctrl #(
    .POWERUP_CYCLES  (POWERUP_CYCLES),
    .RST_PULSE_CYCLES(RST_PULSE_CYCLES),
    .POST_RST_CYCLES (POST_RST_CYCLES),
    .PREAMBLE_BITS   (PREAMBLE_BITS),
    .HALF_DIV        (HALF_DIV)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .phyRstReq(phyRstReq),
    .mdcFall  (mdcFall),
    .strb     (strb),
    .busy     (busy),
    .done     (done),
    .phyRstN  (phyRstN)
  );

  mdio_datapath #(
    .HALF_DIV(HALF_DIV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqWrite  (reqWrite),
    .reqPhyAddr(reqPhyAddr),
    .reqRegAddr(reqRegAddr),
    .reqWrData (reqWrData),
    .mdioIn    (mdioIn),
    .mdc       (mdc),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe),
    .mdcFall   (mdcFall),
    .rdData    (rdData),
    .taError   (taError)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int POST_RST_CYCLES = 400
) (
  input logic clk,
  input logic rstN,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe,
  input logic phyRstN,
  input logic busy,
  input logic done
);

  // Cycles since the PHY reset pin last went high, saturating
  logic [31:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN || !phyRstN)                      sinceRst <= '0;
    else if (sinceRst < 32'(POST_RST_CYCLES))   sinceRst <= sinceRst + 1;
  end

  AST_RST_NO_MDC: assert property (@(posedge clk) disable iff (!rstN)
    !phyRstN |-> !mdc); // R2

  AST_POST_RST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> (sinceRst >= 32'(POST_RST_CYCLES))); // R3

  AST_MDIO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe))); // R6

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R11

endmodule

bind mdio_master mdio_master_chk #(.POST_RST_CYCLES(POST_RST_CYCLES)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .mdc    (mdc),
  .mdioOut(mdioOut),
  .mdioOe (mdioOe),
  .phyRstN(phyRstN),
  .busy   (busy),
  .done   (done)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

  localparam int PWR  = 40;
  localparam int RSTP = 6;
  localparam int POST = 15;
  localparam int PRE  = 36;
  localparam int HALF = 2;
  localparam logic [4:0] MY_PHY = 5'd1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, phyRstReq = 1'b0;
  logic [4:0]  reqPhyAddr = '0, reqRegAddr = '0;
  logic [15:0] reqWrData = '0;
  logic        busy, done, taError, mdc, mdioOut, mdioOe, mdioIn, phyRstN;
  logic [15:0] rdData;

  always #5 clk = ~clk;

  // PHY side: line pulled high when nobody drives it
  logic phyDrv = 1'b0, phyVal = 1'b1;
  assign mdioIn = mdioOe ? mdioOut : (phyDrv ? phyVal : 1'b1);

  mdio_master #(
    .POWERUP_CYCLES(PWR), .RST_PULSE_CYCLES(RSTP), .POST_RST_CYCLES(POST),
    .PREAMBLE_BITS(PRE), .HALF_DIV(HALF)
  ) u_mdio_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPhyAddr(reqPhyAddr), .reqRegAddr(reqRegAddr), .reqWrData(reqWrData),
    .phyRstReq(phyRstReq), .busy(busy), .done(done), .rdData(rdData),
    .taError(taError), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn), .phyRstN(phyRstN)
  );

  int vectors = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wrVal(input int r);
    return 16'h5A00 ^ 16'(r * 16'h0321);
  endfunction

  // ---------------- PHY model ----------------
  logic [15:0] mreg [32];
  int   phase = 0, ones = 0, bitCnt = 0, rdCnt = 0, skipCnt = 0;
  int   frames = 0, preBad = 0, taBad = 0, lastPre = 0;
  logic [13:0] hdr;
  logic [17:0] wbuf;
  logic [15:0] rdWord;
  logic [4:0]  wAddr;

  initial for (int i = 0; i < 32; i++) mreg[i] = 16'hC0DE ^ 16'(i);

  always @(posedge mdc) begin
    case (phase)
      0: begin
        if (mdioIn) ones++;
        else if (ones >= 32) begin
          lastPre = ones;
          if (ones != PRE) preBad++;        // R4
          hdr = '0; bitCnt = 1; phase = 1;
        end else ones = 0;
      end
      1: begin
        hdr = {hdr[12:0], mdioIn};
        bitCnt++;
        if (bitCnt == 14) begin
          if (hdr[13:12] == 2'b01 && (hdr[9:5] == MY_PHY || hdr[9:5] == 5'd0) &&
              (hdr[11:10] == 2'b10 || hdr[11:10] == 2'b01)) begin
            frames++;
            if (hdr[11:10] == 2'b10) begin
              phyDrv = 1'b0; rdWord = mreg[hdr[4:0]]; rdCnt = 0; phase = 2;
            end else begin
              wAddr = hdr[4:0]; bitCnt = 0; phase = 3;
            end
          end else begin
            skipCnt = 0; phase = 4;
          end
        end
      end
      2: begin
        rdCnt++;
        if (rdCnt == 1) begin phyDrv = 1'b1; phyVal = 1'b0; end
        else if (rdCnt <= 17) phyVal = rdWord[17 - rdCnt];
        else begin phyDrv = 1'b0; phase = 0; ones = 0; end
      end
      3: begin
        wbuf = {wbuf[16:0], mdioIn};
        bitCnt++;
        if (bitCnt == 18) begin
          if (wbuf[17:16] != 2'b10) taBad++;   // R7
          mreg[wAddr] = wbuf[15:0];
          phase = 0; ones = 0;
        end
      end
      default: begin
        skipCnt++;
        if (skipCnt == 18) begin phase = 0; ones = 0; end
      end
    endcase
  end

  // ---------------- timing monitor ----------------
  int  cyc = 0, rstLow = 0, rstRiseCyc = 0, gap = -1, firstRise = -1, rstFallCyc = -1;
  int  lastRiseCyc = -100, minPeriod = 1000, stabBad = 0;
  bit  pendGap = 1'b0;
  logic prevMdc = 1'b0, prevRst = 1'b1, prevOut = 1'b0, prevOe = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (prevRst && !phyRstN) begin rstLow = 0; if (rstFallCyc < 0) rstFallCyc = cyc; end
      if (!phyRstN) rstLow++;
      if (!prevRst && phyRstN) begin rstRiseCyc = cyc; pendGap = 1'b1; end
      if (!prevMdc && mdc) begin
        if (firstRise < 0) firstRise = cyc;
        if (pendGap) begin gap = cyc - rstRiseCyc; pendGap = 1'b0; end
        if (cyc - lastRiseCyc < minPeriod) minPeriod = cyc - lastRiseCyc;
        lastRiseCyc = cyc;
      end
      if (prevMdc && mdc && (prevOut != mdioOut || prevOe != mdioOe)) stabBad++;
    end
    prevMdc = mdc; prevRst = phyRstN; prevOut = mdioOut; prevOe = mdioOe;
  end

  // ---------------- transaction task ----------------
  task automatic xfer(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                      input logic [15:0] wd, output logic [15:0] rd, output logic ta);
    while (busy) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqPhyAddr = pa; reqRegAddr = ra; reqWrData = wd;
    do @(negedge clk); while (!busy);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    rd = rdData; ta = taError;
    @(negedge clk);
  endtask

  logic [15:0] rd;
  logic        ta;
  int          f0;

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after reset", 32'(busy), 1);
    chk(mdc == 1'b0, "R1 mdc idle after reset", 32'(mdc), 0);
    chk(phyRstN == 1'b1, "R1 phyRstN high in power-up", 32'(phyRstN), 1);
    chk(mdioOe == 1'b0, "R1 mdio released", 32'(mdioOe), 0);
    chk(done == 1'b0, "R11 no done at reset", 32'(done), 0);

    // First request is queued during the waits
    xfer(1'b1, MY_PHY, 5'd0, wrVal(0), rd, ta);
    chk(rstFallCyc >= PWR, "R1 power-up window", 32'(rstFallCyc), PWR);
    chk(firstRise >= PWR + RSTP + POST, "R1 first MDC edge", 32'(firstRise), PWR + RSTP + POST);
    chk(rstLow == RSTP, "R2 reset pulse width", 32'(rstLow), RSTP);
    chk(gap >= POST, "R3 post-reset quiet", 32'(gap), POST);
    chk(lastPre == PRE, "R4 preamble length", 32'(lastPre), PRE);

    // R5/R7: write sweep over every register of the PHY
    for (int r = 1; r < 32; r++) begin
      xfer(1'b1, MY_PHY, 5'(r), wrVal(r), rd, ta);
      chk(ta == 1'b0, "R9 write clears taError", 32'(ta), 0);
    end
    for (int r = 0; r < 32; r++)
      chk(mreg[r] == wrVal(r), "R7 write data landed", 32'(mreg[r]), 32'(wrVal(r)));

    // R8: read sweep
    for (int r = 0; r < 32; r++) begin
      xfer(1'b0, MY_PHY, 5'(r), 16'h0, rd, ta);
      chk(rd == wrVal(r), "R8 read data", 32'(rd), 32'(wrVal(r)));
      chk(ta == 1'b0, "R9 turnaround driven", 32'(ta), 0);
    end

    // R10: PHY address 0
    for (int r = 0; r < 32; r += 7) begin
      xfer(1'b0, 5'd0, 5'(r), 16'h0, rd, ta);
      chk(rd == wrVal(r), "R10 read via address 0", 32'(rd), 32'(wrVal(r)));
    end

    // R9: absent PHY
    xfer(1'b0, 5'd7, 5'd2, 16'h0, rd, ta);
    chk(ta == 1'b1, "R9 absent PHY flagged", 32'(ta), 1);
    chk(rd == 16'hFFFF, "R8 absent PHY reads pulled-up line", 32'(rd), 32'hFFFF);
    xfer(1'b1, MY_PHY, 5'd9, wrVal(9), rd, ta);
    chk(ta == 1'b0, "R9 cleared by next write", 32'(ta), 0);

    // R11: request while busy is ignored
    while (busy) @(negedge clk);
    f0 = frames;
    reqValid = 1'b1; reqWrite = 1'b1; reqPhyAddr = MY_PHY; reqRegAddr = 5'd3; reqWrData = 16'hBEEF;
    do @(negedge clk); while (!busy);
    reqValid = 1'b0;
    repeat (30) @(negedge clk);
    reqValid = 1'b1; reqRegAddr = 5'd4; reqWrData = 16'hDEAD;
    repeat (10) @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(frames == f0 + 1, "R11 one frame per accept", 32'(frames - f0), 1);
    xfer(1'b0, MY_PHY, 5'd4, 16'h0, rd, ta);
    chk(rd == wrVal(4), "R11 busy request ignored", 32'(rd), 32'(wrVal(4)));
    xfer(1'b0, MY_PHY, 5'd3, 16'h0, rd, ta);
    chk(rd == 16'hBEEF, "R5 write to reg 3", 32'(rd), 32'hBEEF);

    // R2/R3: reset on request, with reqValid present at the same time
    while (busy) @(negedge clk);
    f0 = frames;
    phyRstReq = 1'b1; reqValid = 1'b1; reqWrite = 1'b0; reqPhyAddr = MY_PHY; reqRegAddr = 5'd5;
    @(negedge clk);
    phyRstReq = 1'b0; reqValid = 1'b0;
    chk(phyRstN == 1'b0, "R2 phyRstReq wins", 32'(phyRstN), 0);
    xfer(1'b0, MY_PHY, 5'd5, 16'h0, rd, ta);
    chk(frames == f0 + 1, "R2 simultaneous request dropped", 32'(frames - f0), 1);
    chk(rstLow == RSTP, "R2 requested pulse width", 32'(rstLow), RSTP);
    chk(gap >= POST, "R3 quiet after requested reset", 32'(gap), POST);
    chk(rd == wrVal(5), "R8 read after reset", 32'(rd), 32'(wrVal(5)));

    chk(preBad == 0, "R4 preamble lengths", 32'(preBad), 0);
    chk(taBad == 0, "R7 write turnaround 1,0", 32'(taBad), 0);
    chk(stabBad == 0, "R6 MDIO stable while MDC high", 32'(stabBad), 0);
    chk(minPeriod == 2 * HALF, "R6 MDC period", 32'(minPeriod), 2 * HALF);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++; errors++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule